// File: doc/BRIEF.md
# Serial Receive Status Controller

This block stands between a serial deserializer and an 8-bit register port. The deserializer hands it finished characters and break events. The block keeps the most recent character in a receive data register. It tracks the receive-full, overrun, framing-error and parity-error conditions in a status register, and it signals software through a one-cycle receive pulse and a level error interrupt. Bit sampling, parity computation and the transmit path are not part of this block.

Incoming characters are rate-limited. After a character is accepted, further characters are refused for `HOLD_CYCLES` clock cycles, which is one character time. A character that arrives while the previous one is still unread does not overwrite it; it is flagged as an overrun. Error flags are cleared by a handshake: software first reads the status register while an error is showing, then writes zeros to the error bits. Only after that sequence does the error interrupt drop.

Register offsets: 0 is the control register, 1 is the status register, 2 is the receive data register, and 3 is unused (reads 0).

Top module: `serial_rx_status`

## Requirements
- R1: A character offered on `char_valid` is accepted only if control bit 0 (receive enable) is 1 and the holdoff window has expired. A refused character changes no register and raises no interrupt.
- R2: Every accepted character, stored or overrun, refuses further characters for the next `HOLD_CYCLES - 1` cycles. A character offered exactly `HOLD_CYCLES` cycles after an accepted one is accepted.
- R3: If an accepted character arrives while receive-full (status bit 6) is set, the data register is left unchanged and overrun (status bit 5) is set. `err_irq` rises on the next cycle if control bit 1 (receive interrupt enable) is 1.
- R4: Otherwise the accepted character is stored and receive-full is set. `rx_irq` is high for exactly the one cycle after acceptance if control bit 1 is 1.
- R5: A read at offset 2 returns the held character and clears receive-full.
- R6: A `break_evt` pulse sets framing error (status bit 4). It raises `err_irq` only when control bit 1 is 1.
- R7: The status byte is, from bit 7 down: transmit-empty, receive-full, overrun, framing error, parity error, transmit-end, multiprocessor bit, multiprocessor bit to send. It reads 0x84 after reset; bits 7 and 2 read 1 and bit 1 reads 0 in this receive-only block.
- R8: A write at offset 1 changes only bit 0 and the error bits 5..3. `err_irq` falls when the latest status read before the write showed an error and the written error bits are all zero; otherwise it stays as it was.
- R9: A write at offset 0 stores the whole byte. Writing it with bit 1 clear drops `err_irq` on the next cycle.
- R10: A write at offset 2 changes neither the held character nor receive-full.
- R11: After reset `rx_irq` and `err_irq` are low, the control and data registers read 0x00, and receive-full is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access; side effects at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| char_valid | input | 1 | Deserializer offers a character this cycle |
| char_data | input | CHAR_W | Offered character |
| break_evt | input | 1 | Break condition seen on the line, one-cycle pulse |
| rx_irq | output | 1 | Receive interrupt, one-cycle pulse |
| err_irq | output | 1 | Error interrupt, level |

## Verification
The hardest cases to reach involve timing and history. One is the holdoff edge: one character must be offered one cycle too early and the next exactly on time. The stimulus produces this by sending a character, idling `HOLD_CYCLES - 2` cycles, and then offering two characters back to back. If the refusal were taken as an acceptance, the early character would overrun and `err_irq` would already be high. The other is the clear handshake, which depends on what an earlier status read showed. The stimulus writes zeros once after a read that showed no error, where the interrupt must stay high, and again after a read that showed an error, where it must fall.

// File: rtl/srs_pkg.sv
package srs_pkg;
   localparam int unsigned REG_W = 8;

   typedef enum logic [1:0] {
      OFS_CTRL  = 2'd0,
      OFS_STAT  = 2'd1,
      OFS_DATA  = 2'd2,
      OFS_SPARE = 2'd3
   } reg_ofs_e;

   // status bit positions (software decodes these)
   localparam int unsigned SB_TXEMPTY = 7;
   localparam int unsigned SB_FULL    = 6;
   localparam int unsigned SB_OVR     = 5;
   localparam int unsigned SB_FRM     = 4;
   localparam int unsigned SB_PAR     = 3;
   localparam int unsigned SB_TXEND   = 2;
   localparam int unsigned SB_MPIN    = 1;
   localparam int unsigned SB_MPOUT   = 0;

   // control bit positions
   localparam int unsigned CB_RXEN = 0;
   localparam int unsigned CB_RIE  = 1;
endpackage

// File: rtl/srs_holdoff.sv
module srs_holdoff #(
   parameter int unsigned HOLD_CYCLES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   output logic ready
);
   localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

   generate
      if (HOLD_CYCLES <= 1) begin : g_free
         assign ready = 1'b1;
      end else begin : g_count
         localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);
         logic [CNT_W-1:0] left_q;

         always_ff @(posedge clk) begin
            if (!rst_n)            left_q <= '0;
            else if (take)         left_q <= RELOAD;
            else if (left_q != '0) left_q <= left_q - 1'b1;
         end

         assign ready = (left_q == '0);

         AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> !ready); // R2
      end
   endgenerate
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
   import srs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] value,
   output logic             rx_en,
   output logic             rie
);
   logic [REG_W-1:0] ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  ctrl_q <= '0;
      else if (wr) ctrl_q <= wdata;
   end

   assign value = ctrl_q;
   assign rx_en = ctrl_q[CB_RXEN];
   assign rie   = ctrl_q[CB_RIE];
endmodule

// File: rtl/srs_flags.sv
module srs_flags
   import srs_pkg::*;
#(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rie,
   input  logic              accept,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              break_evt,
   input  logic              stat_rd,
   input  logic              stat_wr,
   input  logic              data_rd,
   input  logic              ctrl_quiet,
   input  logic              wr_mpout,
   input  logic [2:0]        wr_err,
   output logic [REG_W-1:0]  status,
   output logic [REG_W-1:0]  held,
   output logic              rx_irq,
   output logic              err_irq
);
   logic              full_q, ovr_q, frm_q, par_q, mpout_q, snap_err_q;
   logic [CHAR_W-1:0] data_q;
   logic              rx_irq_q, err_irq_q;

   logic store, overrun, err_set, err_clr;
   assign store   = accept & ~full_q;
   assign overrun = accept &  full_q;
   assign err_set = (overrun | break_evt) & rie;
   assign err_clr = ctrl_quiet | (stat_wr & snap_err_q & ~(|wr_err));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q     <= 1'b0;
         ovr_q      <= 1'b0;
         frm_q      <= 1'b0;
         par_q      <= 1'b0;
         mpout_q    <= 1'b0;
         snap_err_q <= 1'b0;
         data_q     <= '0;
         rx_irq_q   <= 1'b0;
         err_irq_q  <= 1'b0;
      end else begin
         if (store)        full_q <= 1'b1;
         else if (data_rd) full_q <= 1'b0;

         if (store) data_q <= char_data;

         if (stat_wr) begin
            mpout_q <= wr_mpout;
            ovr_q   <= wr_err[2] | overrun;
            frm_q   <= wr_err[1] | break_evt;
            par_q   <= wr_err[0];
         end else begin
            ovr_q <= ovr_q | overrun;
            frm_q <= frm_q | break_evt;
         end

         if (stat_rd) snap_err_q <= ovr_q | frm_q | par_q;

         rx_irq_q <= store & rie;

         if (err_set)      err_irq_q <= 1'b1;
         else if (err_clr) err_irq_q <= 1'b0;
      end
   end

   always_comb begin
      status             = '0;
      status[SB_TXEMPTY] = 1'b1;
      status[SB_FULL]    = full_q;
      status[SB_OVR]     = ovr_q;
      status[SB_FRM]     = frm_q;
      status[SB_PAR]     = par_q;
      status[SB_TXEND]   = 1'b1;
      status[SB_MPIN]    = 1'b0;
      status[SB_MPOUT]   = mpout_q;
   end

   generate
      if (CHAR_W == REG_W) begin : g_exact
         assign held = data_q;
      end else begin : g_pad
         assign held = {{(REG_W-CHAR_W){1'b0}}, data_q};
      end
   endgenerate

   assign rx_irq  = rx_irq_q;
   assign err_irq = err_irq_q;

   AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_q |=> !rx_irq_q); // R4
   AST_RX_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_q |-> full_q); // R4
   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> $stable(data_q)); // R3
   AST_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> ovr_q); // R3
   AST_DATA_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !store) |=> !full_q); // R5
   AST_BREAK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      break_evt |=> frm_q); // R6
   AST_ERR_NEEDS_RIE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_irq_q) |-> $past(rie)); // R6
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
   import srs_pkg::*;
#(
   parameter int unsigned CHAR_W      = 8,
   parameter int unsigned HOLD_CYCLES = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              char_valid,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              break_evt,
   output logic              rx_irq,
   output logic              err_irq
);
   generate
      if (CHAR_W < 1 || CHAR_W > REG_W) begin : g_bad_char_w
         $error("serial_rx_status: CHAR_W must lie in 1..8");
      end
   endgenerate

   logic wr_ctrl, wr_stat, rd_stat, rd_data;
   assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
   assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
   assign rd_stat = reg_rd && (reg_addr == OFS_STAT);
   assign rd_data = reg_rd && (reg_addr == OFS_DATA);

   logic [REG_W-1:0] ctrl_val, stat_val, data_val;
   logic             rx_en, rie, ready, accept;

   srs_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ctrl),
      .wdata (reg_wdata),
      .value (ctrl_val),
      .rx_en (rx_en),
      .rie   (rie)
   );

   assign accept = char_valid & rx_en & ready;

   srs_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (accept),
      .ready (ready)
   );

   srs_flags #(.CHAR_W(CHAR_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .rie        (rie),
      .accept     (accept),
      .char_data  (char_data),
      .break_evt  (break_evt),
      .stat_rd    (rd_stat),
      .stat_wr    (wr_stat),
      .data_rd    (rd_data),
      .ctrl_quiet (wr_ctrl & ~reg_wdata[CB_RIE]),
      .wr_mpout   (reg_wdata[SB_MPOUT]),
      .wr_err     ({reg_wdata[SB_OVR], reg_wdata[SB_FRM], reg_wdata[SB_PAR]}),
      .status     (stat_val),
      .held       (data_val),
      .rx_irq     (rx_irq),
      .err_irq    (err_irq)
   );

   always_comb begin
      unique case (reg_addr)
         OFS_CTRL: reg_rdata = ctrl_val;
         OFS_STAT: reg_rdata = stat_val;
         OFS_DATA: reg_rdata = data_val;
         default:  reg_rdata = '0;
      endcase
   end

   AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !rx_en) |=> !rx_irq); // R1
   AST_CTRL_QUIETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !reg_wdata[CB_RIE] && !break_evt && !char_valid) |=> !err_irq); // R9
   AST_DATA_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_DATA && !char_valid) |=> $stable(data_val)); // R10
endmodule

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb;
   localparam int TCK  = 10;
   localparam int HOLD = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       char_valid = 1'b0;
   logic [7:0] char_data = 8'h00;
   logic       break_evt = 1'b0;
   logic       rx_irq, err_irq;

   int total = 0, bad = 0;
   bit done = 0;

   always #(TCK/2) clk = ~clk;

   serial_rx_status #(.CHAR_W(8), .HOLD_CYCLES(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .char_valid(char_valid), .char_data(char_data), .break_evt(break_evt),
      .rx_irq(rx_irq), .err_irq(err_irq)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_ctrl, m_full, m_ovr, m_frm, m_par, m_mpo, m_data, m_snap;
   int m_rx, m_err;
   longint cyc, next_ok;

   function automatic int model_read(int a);
      case (a)
         0: return m_ctrl;
         1: return 128 + m_full*64 + m_ovr*32 + m_frm*16 + m_par*8 + 4 + m_mpo;
         2: return m_data;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_full = 0; m_ovr = 0; m_frm = 0; m_par = 0; m_mpo = 0;
         m_data = 0; m_snap = 0; m_rx = 0; m_err = 0; cyc = 0; next_ok = 0;
      end else begin
         int rxen, rie, acc, st, ov, setv, clrv, w_err;
         rxen  = m_ctrl & 1;
         rie   = (m_ctrl >> 1) & 1;
         acc   = (char_valid && rxen && cyc >= next_ok) ? 1 : 0;
         st    = acc && !m_full;
         ov    = acc && m_full;
         w_err = (reg_wdata >> 3) & 7;
         setv  = (ov || break_evt) && rie;
         clrv  = (reg_wr && reg_addr == 0 && !reg_wdata[1]) ||
                 (reg_wr && reg_addr == 1 && m_snap && w_err == 0);
         if (acc) next_ok = cyc + HOLD;
         m_rx = st && rie;
         if (setv) m_err = 1; else if (clrv) m_err = 0;
         if (reg_rd && reg_addr == 1) m_snap = (m_ovr || m_frm || m_par) ? 1 : 0;
         if (st) begin m_data = char_data; m_full = 1; end
         else if (reg_rd && reg_addr == 2) m_full = 0;
         if (reg_wr && reg_addr == 1) begin
            m_mpo = reg_wdata[0];
            m_ovr = reg_wdata[5] | ov;
            m_frm = reg_wdata[4] | break_evt;
            m_par = reg_wdata[3];
         end else begin
            m_ovr = m_ovr | ov;
            m_frm = m_frm | break_evt;
         end
         if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata;
         cyc++;
      end
   end

   always @(posedge clk) begin
      #(TCK/4);
      if (rst_n && !done) begin
         check("R4 rx_irq vs model", rx_irq, m_rx);
         check("R6 err_irq vs model", err_irq, m_err);
         check("R7 rdata vs model", reg_rdata, model_read(reg_addr));
      end
   end

   // ---------------- stimulus tasks (entered at a negedge) ----------------
   task automatic wr(int a, int v);
      reg_addr = a[1:0]; reg_wdata = v[7:0]; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(int a, output int v);
      reg_addr = a[1:0]; reg_rd = 1'b1; #1 v = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic send(int d);
      char_data = d[7:0]; char_valid = 1'b1;
      @(negedge clk); char_valid = 1'b0;
   endtask

   task automatic brk();
      break_evt = 1'b1; @(negedge clk); break_evt = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(TCK*100000);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 rx_irq after reset", rx_irq, 0);
      check("R11 err_irq after reset", err_irq, 0);
      rd(0, v); check("R11 ctrl after reset", v, 8'h00);
      rd(2, v); check("R11 data after reset", v, 8'h00);
      rd(1, v); check("R7 status after reset", v, 8'h84);

      // R1 disabled receiver ignores characters
      send(8'h11);
      check("R1 no rx_irq when disabled", rx_irq, 0);
      rd(1, v); check("R1 status untouched", v, 8'h84);
      rd(2, v); check("R1 data untouched", v, 8'h00);

      // R4 first character stored
      wr(0, 8'h03);
      send(8'hA5);
      check("R4 rx_irq pulse", rx_irq, 1);
      send(8'h33);  // R2 within holdoff, refused
      check("R4 rx_irq single cycle", rx_irq, 0);
      rd(1, v); check("R4 R2 status full, no overrun", v, 8'hC4);

      // R3 overrun after holdoff
      idle(HOLD);
      send(8'h5A);
      check("R3 err_irq raised", err_irq, 1);
      check("R3 no rx_irq on overrun", rx_irq, 0);
      rd(2, v); check("R3 data kept", v, 8'hA5);

      // R8 write zero without an erroring read first
      wr(1, 8'h00);
      check("R8 err_irq held without read", err_irq, 1);
      rd(1, v); check("R5 R8 status after data read and write", v, 8'h84);

      // R10 data register write ignored
      wr(2, 8'h77);
      rd(2, v); check("R10 data unchanged", v, 8'hA5);
      rd(1, v); check("R10 full not set", v, 8'h84);

      // R8 proper handshake
      wr(1, 8'h28);
      rd(1, v); check("R8 error bits written", v, 8'hAC);
      check("R8 err_irq still high", err_irq, 1);
      wr(1, 8'hC1);
      check("R8 err_irq cleared", err_irq, 0);
      rd(1, v); check("R8 only bit0 and errors change", v, 8'h85);

      // R6 break
      brk();
      check("R6 err_irq on break", err_irq, 1);
      rd(1, v); check("R6 framing flag", v, 8'h95);
      // R9 control write with enable clear
      wr(0, 8'h01);
      check("R9 err_irq dropped", err_irq, 0);
      rd(0, v); check("R9 ctrl stored", v, 8'h01);
      brk();
      check("R6 break without enable", err_irq, 0);
      rd(1, v); wr(1, 8'h00);
      rd(1, v); check("R8 flags cleared", v, 8'h84);

      // R2 holdoff boundary
      wr(0, 8'h03);
      idle(HOLD);
      send(8'h10);
      check("R2 first accepted", rx_irq, 1);
      idle(HOLD-2);
      send(8'h20);
      check("R2 early char refused", err_irq, 0);
      send(8'h30);
      check("R2 on-time char accepted as overrun", err_irq, 1);
      rd(2, v); check("R2 data is first char", v, 8'h10);
      rd(1, v); check("R5 full cleared by read", v, 8'hA4);

      // R5 re-fill after read
      rd(1, v); wr(1, 8'h00);
      idle(HOLD);
      send(8'h6C);
      check("R5 store after read", rx_irq, 1);
      rd(2, v); check("R5 new char", v, 8'h6C);
      idle(2);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule